// File: doc/BRIEF.md
# Dual-Address I2C Slave with Memory Request Port

This block is an I2C slave that sits behind a line-conditioning front end. It receives SCL and SDA levels that are already synchronised and filtered, finds START and STOP itself, and drives open-drain pull-down enables for both lines. It answers two bus addresses, each set by its own input pins. A transaction to the configuration address reads or writes one 8-bit control and status register. A transaction to the memory address becomes a stream of single-byte requests on a valid/ready port. Every write data byte makes one write request. Every byte the master reads is fetched by one read request.

The requester on the far side of the memory port answers in the same cycle as `mem_req_ready`. It returns read data and two flags: a bus error and an access outside the permitted window. Both flags are kept in the status register. The register's control bits set the transfer size shown to the requester and a NACK policy for failed writes.

Back-pressure works as follows. `mem_req_valid` rises one cycle after the SCL edge that needs a byte. A handshake is a cycle in which valid and ready are both high, and the response fields are taken in that cycle. With stretching enabled, the slave holds SCL low until the handshake, and valid is not dropped before ready. With stretching disabled, the request stays up only while SCL is low. If SCL rises first, the request is withdrawn with no handshake.

Top module: `i2c_dual_slave`

## Requirements
- R1: After a START, the slave takes a 7-bit address MSB first and then an R/W bit (1 = read). When the address equals `cfg_addr` or `mem_addr`, it pulls SDA low during the ninth clock (ACK). If the two addresses are equal, the configuration address wins.
- R2: When the address matches neither input, the slave does not acknowledge it. SDA stays released for the rest of the frame and no memory request is made, until the next START.
- R3: A byte written to the configuration address sets bit 2 (NACK policy) and bits 1:0 (size: 00 byte, 01 halfword, 10 word). Writes to bits 7:3 are ignored. Writing size code 11 leaves the size field unchanged. `mem_req_size` always shows bits 1:0.
- R4: A read from the configuration address returns this byte, MSB first: bits 7:6 are zero, bit 5 is the protection flag, bit 4 is the error flag, bit 3 is the memory-activity flag, and bits 2:0 are the control bits.
- R5: Each data byte written to the memory address produces exactly one request with `mem_req_write`=1 and `mem_req_wdata` equal to the byte.
- R6: Each byte read from the memory address is fetched by one request with `mem_req_write`=0 and sent MSB first. A further byte is fetched only after the master ACKs the previous one, so a master NACK causes no extra fetch.
- R7: With `stretch_en`=1, the slave holds SCL low (`scl_oe`=1) from the cycle after the SCL fall that needs a byte until one cycle after the handshake. While SCL is held, valid stays high until ready.
- R8: With `stretch_en`=0, `scl_oe` is never asserted. A request not accepted before SCL rises is withdrawn. A write byte in that case is answered NACK. A read byte in that case is sent as all ones, and the slave stays silent until the next START.
- R9: With bit 2 set, a memory write byte whose handshake returns error or protection is answered NACK. With bit 2 clear, it is answered ACK.
- R10: Every handshake replaces bit 5 with `mem_rsp_prot` and bit 4 with `mem_rsp_err` as sampled in that cycle. The two flags change at no other time.
- R11: `mem_active` (bit 3) is 1 from the acknowledged memory address until the transaction ends (STOP, START, or the slave dropping out). `mem_req_valid` is only high while it is 1.
- R12: `sda_oe` changes only when SCL was low in the cycle before. It is stable through every SCL high phase.
- R13: After reset, and after any STOP, both line enables are released and no request is pending. After reset, the control bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Conditioned SCL level |
| sda_i | input | 1 | Conditioned SDA level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| cfg_addr | input | AW | Configuration register bus address |
| mem_addr | input | AW | Memory bridge bus address |
| stretch_en | input | 1 | Allow clock stretching |
| mem_req_valid | output | 1 | Byte request offered |
| mem_req_ready | input | 1 | Requester accepts; response fields valid |
| mem_req_write | output | 1 | 1 = write request, 0 = read request |
| mem_req_wdata | output | DW | Write byte |
| mem_req_size | output | 2 | Access size code from the register |
| mem_rsp_rdata | input | DW | Read byte, sampled on handshake |
| mem_rsp_err | input | 1 | Error response, sampled on handshake |
| mem_rsp_prot | input | 1 | Outside-window response, sampled on handshake |
| mem_active | output | 1 | A memory transaction is under way |

## Verification
The hardest case to reach is a request that is withdrawn. This happens when stretching is off and the requester has not answered before the master raises SCL. It needs a requester latency much longer than the SCL low phase. The bench builds it directly, with a latency of 200 cycles and stretching off, for both a write byte and a read byte. It then checks the NACK, the all-ones byte, and that no handshake took place. The rest of the stimulus comes from a fixed-seed random mix of configuration and memory transactions. It varies latency, stretching, response flags and the NACK policy. Each result is compared with a bench model of the register and the request stream.

// File: rtl/i2cds_pkg.sv
package i2cds_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ACKD, ST_WR, ST_RD, ST_MACK, ST_REQ, ST_REL, ST_IGN
  } st_e;

  localparam int F_PROT = 5;
  localparam int F_ERR  = 4;
  localparam int F_ACT  = 3;
  localparam int F_NACK = 2;
  localparam logic [1:0] SZ_RSVD = 2'b11;
endpackage

// File: rtl/i2cds_linemon.sv
module i2cds_linemon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SDA moving while SCL stays high marks START (falling) or STOP (rising)
  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cds_cfgreg.sv
module i2cds_cfgreg import i2cds_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_data,
  input  logic          upd_en,
  input  logic          upd_err,
  input  logic          upd_prot,
  input  logic          active,
  output logic [DW-1:0] rd_val,
  output logic [1:0]    size,
  output logic          nack_mode
);
  logic [1:0] size_q;
  logic       nack_q, err_q, prot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= 2'b00;
      nack_q <= 1'b0;
      err_q  <= 1'b0;
      prot_q <= 1'b0;
    end else begin
      if (wr_en) begin
        nack_q <= wr_data[2];
        if (wr_data[1:0] != SZ_RSVD) size_q <= wr_data[1:0];
      end
      if (upd_en) begin
        err_q  <= upd_err;
        prot_q <= upd_prot;
      end
    end
  end

  always_comb begin
    rd_val         = '0;
    rd_val[F_PROT] = prot_q;
    rd_val[F_ERR]  = err_q;
    rd_val[F_ACT]  = active;
    rd_val[F_NACK] = nack_q;
    rd_val[1:0]    = size_q;
  end

  assign size      = size_q;
  assign nack_mode = nack_q;
endmodule

// File: rtl/i2cds_fsm.sv
module i2cds_fsm import i2cds_pkg::*; #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_c,
  input  logic          stop_c,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] mem_addr,
  input  logic          stretch_en,
  input  logic          nack_mode,
  input  logic [DW-1:0] cfg_rd,
  output logic          sda_oe,
  output logic          scl_oe,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] rsp_rdata,
  input  logic          rsp_err,
  input  logic          rsp_prot,
  output logic          cfg_we,
  output logic [2:0]    cfg_wdata,
  output logic          upd_en,
  output logic          active
);
  localparam int FW = AW + 1;
  localparam int SW = (FW > DW) ? FW : DW;
  localparam int CW = $clog2(SW + 1);

  st_e           st;
  logic [SW-1:0] sh;
  logic [DW-1:0] tx;
  logic [CW-1:0] cnt;
  logic          rw, tgt_mem, ack_q, req_rd, macked;
  logic          hs, wr_ack;

  assign req_valid = (st == ST_REQ) && (stretch_en || !scl_i);
  assign hs        = req_valid && req_ready;
  assign wr_ack    = !(nack_mode && (rsp_err || rsp_prot));
  assign req_write = !req_rd;
  assign req_wdata = sh[DW-1:0];
  assign upd_en    = hs;
  assign scl_oe    = stretch_en && ((st == ST_REQ) || (st == ST_REL));
  assign cfg_we    = (st == ST_WR) && scl_fall && (cnt == CW'(DW)) && !tgt_mem && !start_c && !stop_c;
  assign cfg_wdata = sh[2:0];
  assign active    = tgt_mem && !(st inside {ST_IDLE, ST_ADDR, ST_IGN});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sh      <= '0;
      tx      <= '0;
      cnt     <= '0;
      rw      <= 1'b0;
      tgt_mem <= 1'b0;
      ack_q   <= 1'b0;
      req_rd  <= 1'b0;
      macked  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (start_c) begin
      st     <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_ADDR: begin
          if (scl_rise) begin
            sh  <= {sh[SW-2:0], sda_i};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == CW'(FW)) begin
            rw <= sh[0];
            if (sh[AW:1] == cfg_addr) begin
              tgt_mem <= 1'b0;
              ack_q   <= 1'b1;
              sda_oe  <= 1'b1;
              st      <= ST_ACKD;
            end else if (sh[AW:1] == mem_addr) begin
              tgt_mem <= 1'b1;
              ack_q   <= 1'b1;
              sda_oe  <= 1'b1;
              st      <= ST_ACKD;
            end else begin
              st <= ST_IGN;
            end
          end
        end
        ST_ACKD: begin
          if (scl_fall) begin
            if (!ack_q) begin
              sda_oe <= 1'b0;
              st     <= ST_IGN;
            end else if (!rw) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= ST_WR;
            end else if (tgt_mem) begin
              sda_oe <= 1'b0;
              req_rd <= 1'b1;
              st     <= ST_REQ;
            end else begin
              tx     <= cfg_rd;
              sda_oe <= ~cfg_rd[DW-1];
              cnt    <= '0;
              st     <= ST_RD;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            sh  <= {sh[SW-2:0], sda_i};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == CW'(DW)) begin
            if (tgt_mem) begin
              req_rd <= 1'b0;
              st     <= ST_REQ;
            end else begin
              ack_q  <= 1'b1;
              sda_oe <= 1'b1;
              st     <= ST_ACKD;
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == CW'(DW)) begin
              sda_oe <= 1'b0;
              st     <= ST_MACK;
            end else begin
              tx     <= tx << 1;
              sda_oe <= ~tx[DW-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            macked <= !sda_i;
          end else if (scl_fall) begin
            if (!macked) begin
              st <= ST_IGN;
            end else if (tgt_mem) begin
              req_rd <= 1'b1;
              st     <= ST_REQ;
            end else begin
              tx     <= cfg_rd;
              sda_oe <= ~cfg_rd[DW-1];
              cnt    <= '0;
              st     <= ST_RD;
            end
          end
        end
        ST_REQ: begin
          if (hs) begin
            if (req_rd) begin
              tx     <= rsp_rdata;
              sda_oe <= ~rsp_rdata[DW-1];
              cnt    <= '0;
            end else begin
              ack_q  <= wr_ack;
              sda_oe <= wr_ack;
            end
            if (stretch_en)  st <= ST_REL;
            else if (req_rd) st <= ST_RD;
            else             st <= ST_ACKD;
          end else if (!stretch_en && scl_i) begin
            sda_oe <= 1'b0;
            st     <= ST_IGN;
          end
        end
        ST_REL: st <= req_rd ? ST_RD : ST_ACKD;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_dual_slave.sv
module i2c_dual_slave import i2cds_pkg::*; #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] mem_addr,
  input  logic          stretch_en,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [DW-1:0] mem_req_wdata,
  output logic [1:0]    mem_req_size,
  input  logic [DW-1:0] mem_rsp_rdata,
  input  logic          mem_rsp_err,
  input  logic          mem_rsp_prot,
  output logic          mem_active
);
  logic          scl_rise, scl_fall, start_c, stop_c;
  logic          cfg_we, upd_en, nack_mode, active;
  logic [2:0]    cfg_wdata;
  logic [DW-1:0] cfg_rd;

  i2cds_linemon u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  i2cds_cfgreg #(.DW(DW)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
    .upd_en(upd_en), .upd_err(mem_rsp_err), .upd_prot(mem_rsp_prot),
    .active(active), .rd_val(cfg_rd), .size(mem_req_size), .nack_mode(nack_mode)
  );

  i2cds_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c),
    .cfg_addr(cfg_addr), .mem_addr(mem_addr), .stretch_en(stretch_en),
    .nack_mode(nack_mode), .cfg_rd(cfg_rd), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_write(mem_req_write),
    .req_wdata(mem_req_wdata), .rsp_rdata(mem_rsp_rdata), .rsp_err(mem_rsp_err),
    .rsp_prot(mem_rsp_prot), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .upd_en(upd_en), .active(active)
  );

  assign mem_active = active;
endmodule

// File: rtl/i2c_dual_slave_chk.sv
module i2c_dual_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       stretch_en,
  input logic       mem_req_valid,
  input logic       mem_req_ready,
  input logic       mem_rsp_err,
  input logic       mem_rsp_prot,
  input logic       mem_active,
  input logic [1:0] flags
);
  assert_sda_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe));

  assert_no_stretch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> stretch_en);

  assert_valid_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && scl_oe) |=> mem_req_valid);

  assert_flags_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> (flags == {$past(mem_rsp_prot), $past(mem_rsp_err)}));

  assert_valid_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_active);

  assert_stop_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> (!sda_oe && !mem_req_valid));
endmodule

bind i2c_dual_slave i2c_dual_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .stretch_en(stretch_en), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_rsp_err(mem_rsp_err), .mem_rsp_prot(mem_rsp_prot),
  .mem_active(mem_active), .flags(cfg_rd[5:4])
);

// File: tb/tb_i2c_dual_slave.sv
module tb_i2c_dual_slave;
  localparam int Q = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic       scl_oe, sda_oe, scl_line, sda_line;
  logic [6:0] cfg_addr = 7'h2A, mem_addr = 7'h51;
  logic       stretch_en = 1'b1;
  logic       valid, ready = 1'b0, wr;
  logic [7:0] wdata, rdata = 8'h00;
  logic [1:0] size;
  logic       err = 1'b0, prot = 1'b0, active;

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  i2c_dual_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .cfg_addr(cfg_addr), .mem_addr(mem_addr),
    .stretch_en(stretch_en), .mem_req_valid(valid), .mem_req_ready(ready),
    .mem_req_write(wr), .mem_req_wdata(wdata), .mem_req_size(size),
    .mem_rsp_rdata(rdata), .mem_rsp_err(err), .mem_rsp_prot(prot), .mem_active(active)
  );

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // requester model
  int         lat = 0, wcnt = 0, n_hs = 0;
  logic       err_set = 1'b0, prot_set = 1'b0;
  logic [7:0] wr_log[$], rd_log[$];
  always @(negedge clk) begin
    if (valid) begin
      if (wcnt >= lat) begin
        ready = 1'b1; rdata = 8'($urandom); err = err_set; prot = prot_set;
      end else begin
        ready = 1'b0; wcnt++;
      end
    end else begin
      ready = 1'b0; wcnt = 0;
    end
  end
  always @(posedge clk) begin
    if (rst_n && valid && ready) begin
      n_hs++;
      if (wr) wr_log.push_back(wdata);
      else    rd_log.push_back(rdata);
    end
  end

  // line monitors
  logic prev_scl = 1'b1, prev_oe = 1'b0, saw_stretch = 1'b0, saw_sda = 1'b0;
  int   hold_bad = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_line && prev_scl && sda_oe !== prev_oe) hold_bad++;
      if (scl_oe) saw_stretch = 1'b1;
      if (sda_oe) saw_sda = 1'b1;
    end
    prev_scl = scl_line;
    prev_oe  = sda_oe;
  end

  // bench model of the register
  logic [2:0] e_ctrl = 3'b000;
  logic       e_err = 1'b0, e_prot = 1'b0;
  function automatic logic [7:0] exp_status();
    return {2'b00, e_prot, e_err, 1'b0, e_ctrl};
  endfunction
  function automatic logic [2:0] next_ctrl(input logic [2:0] cur, input logic [7:0] v);
    return {v[2], (v[1:0] == 2'b11) ? cur[1:0] : v[1:0]};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask
  task automatic wait_high();
    while (!scl_line) tick(1);
  endtask
  task automatic m_start();
    m_sda = 1'b1; m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask
  task automatic m_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; wait_high(); tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask
  task automatic clk_bit(input logic b, output logic s);
    m_sda = b; tick(Q);
    m_scl = 1'b1; wait_high(); tick(Q);
    s = sda_line; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask
  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(!mack, s);
  endtask

  task automatic cfg_write(input logic [7:0] v);
    logic a;
    m_start();
    send_byte({cfg_addr, 1'b0}, a); chk("R1 cfg addr ack", a, 1);
    send_byte(v, a);                chk("R3 cfg data ack", a, 1);
    m_stop();
    e_ctrl = next_ctrl(e_ctrl, v);
    chk("R3 size pins", size, e_ctrl[1:0]);
  endtask
  task automatic cfg_read();
    logic a;
    logic [7:0] v;
    m_start();
    send_byte({cfg_addr, 1'b1}, a); chk("R1 cfg rd ack", a, 1);
    recv_byte(1'b0, v);
    m_stop();
    chk("R4 status byte", v, exp_status());
  endtask
  task automatic mem_write(input int n);
    logic a, ea;
    logic [7:0] v;
    logic [7:0] exp_q[$];
    m_start();
    send_byte({mem_addr, 1'b0}, a); chk("R1 mem addr ack", a, 1);
    chk("R11 active after addr", active, 1);
    for (int i = 0; i < n; i++) begin
      v  = 8'($urandom);
      ea = !(e_ctrl[2] && (err_set || prot_set));
      send_byte(v, a);
      chk("R9 write ack", a, ea);
      exp_q.push_back(v);
      e_err = err_set; e_prot = prot_set;
      if (!a) break;
    end
    m_stop();
    chk("R13 sda released", sda_oe, 0);
    chk("R11 inactive after stop", active, 0);
    chk("R5 request count", wr_log.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < wr_log.size(); i++)
      chk("R5 write byte", wr_log[i], exp_q[i]);
    wr_log.delete();
  endtask
  task automatic mem_read(input int n);
    logic a;
    logic [7:0] got[$];
    logic [7:0] v;
    int h0;
    h0 = n_hs;
    m_start();
    send_byte({mem_addr, 1'b1}, a); chk("R1 mem rd ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, v);
      got.push_back(v);
    end
    m_stop();
    chk("R6 fetch count", n_hs - h0, n);
    for (int i = 0; i < n && i < rd_log.size(); i++) chk("R6 read byte", got[i], rd_log[i]);
    e_err = err_set; e_prot = prot_set;
    rd_log.delete();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R13 actual=running expected=done");
    summary();
  end

  initial begin
    logic a;
    logic [7:0] v;
    int h0, op;
    void'($urandom(32'd20240611));
    tick(5);
    chk("R13 reset sda", sda_oe, 0);
    chk("R13 reset scl", scl_oe, 0);
    chk("R13 reset valid", valid, 0);
    chk("R13 reset size", size, 0);
    chk("R11 reset active", active, 0);
    rst_n = 1'b1;
    tick(3);

    // register access and reserved size code
    cfg_write(8'hFE);
    cfg_read();
    cfg_write(8'h03);
    chk("R3 reserved size kept", size, 2);
    cfg_write(8'h01);
    cfg_read();

    // foreign address
    h0 = n_hs; saw_sda = 1'b0;
    m_start();
    send_byte({7'h33, 1'b0}, a); chk("R2 no ack", a, 0);
    send_byte(8'h00, a);         chk("R2 data ignored", a, 0);
    m_stop();
    chk("R2 sda never driven", saw_sda, 0);
    chk("R2 no request", n_hs - h0, 0);

    // stretched memory traffic
    stretch_en = 1'b1; lat = 3; saw_stretch = 1'b0;
    mem_write(3);
    chk("R7 stretch seen", saw_stretch, 1);
    lat = 2;
    mem_read(3);

    // NACK policy and flags
    cfg_write(8'h04);
    err_set = 1'b1; mem_write(1);
    cfg_read();
    err_set = 1'b0; prot_set = 1'b1; mem_write(1);
    cfg_read();
    cfg_write(8'h00);
    err_set = 1'b1; prot_set = 1'b0; mem_write(1);
    cfg_read();
    err_set = 1'b0;

    // no stretching, slow requester
    stretch_en = 1'b0; lat = 200; saw_stretch = 1'b0;
    h0 = n_hs;
    m_start();
    send_byte({mem_addr, 1'b0}, a);
    send_byte(8'h5A, a); chk("R8 slow write nack", a, 0);
    m_stop();
    m_start();
    send_byte({mem_addr, 1'b1}, a);
    recv_byte(1'b0, v); chk("R8 slow read ones", v, 8'hFF);
    m_stop();
    chk("R8 withdrawn", n_hs - h0, 0);
    chk("R8 never stretched", saw_stretch, 0);
    lat = 0;
    mem_write(2);

    // random mix
    for (int it = 0; it < 24; it++) begin
      stretch_en = 1'($urandom);
      lat        = stretch_en ? int'($urandom % 6) : 0;
      err_set    = ($urandom % 4) == 0;
      prot_set   = ($urandom % 4) == 0;
      op         = int'($urandom % 4);
      case (op)
        0: mem_write(1 + int'($urandom % 3));
        1: mem_read(1 + int'($urandom % 3));
        2: cfg_write(8'($urandom));
        default: cfg_read();
      endcase
    end

    chk("R12 sda stable while scl high", hold_bad, 0);
    summary();
  end
endmodule